// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer

This block is a register-mapped timer peripheral. One shared 16-bit prescaler divides the system clock into a tick. That tick drives a configurable number of 32-bit down-counting channels, from one to eight. Software programs the block through a single-cycle 32-bit register port. Writes take effect at the clock edge on which `sel` and `wr` are both high. Read data is combinational and reflects the current register state while `sel` is high with `wr` low.

Each enabled channel counts down by one on every tick. A channel expires on underflow, so a loaded value N takes N+1 ticks to expire. On expiry the channel does one of two things:
- Auto-restart set: it reloads from its reload register and keeps counting.
- Auto-restart clear: the counter wraps to all ones and the channel clears its own enable bit.

If interrupts are enabled for the channel, expiry sets a sticky pending flag and emits a one-cycle pulse on that channel's own interrupt output.

The address map is as follows:
- Prescaler live value at 0x00.
- Prescaler reload at 0x04.
- Read-only unit description word at 0x08.
- Channel n at 0x10·(n+1), with counter at +0x0, reload at +0x4 and control at +0x8.

Channel control bits are: bit0 enable, bit1 auto-restart, bit2 load, bit3 interrupt enable, bit4 pending.

Top module: `tick_timer_unit`

## Requirements
- R1: Writes to the prescaler value (0x00) and prescaler reload (0x04) keep only bits 15:0. Reading the reload returns it zero-extended. Reading 0x00 returns the live prescaler count.
- R2: The prescaler counts down by one per clock. When it is 0 it emits a tick and reloads. Channels therefore decrement once every (prescaler reload + 1) clocks, and every clock when the reload is 0.
- R3: A channel enabled with counter value N and prescaler reload 0 expires on the (N+1)-th tick after the enabling write. Its interrupt appears 2+N clock cycles after that write's edge.
- R4: On expiry with bit3 set, pending (bit4) becomes 1 and the channel's irq output is high for exactly one cycle. With bit3 clear, neither happens.
- R5: On expiry with auto-restart (bit1) set, the counter reloads from the channel reload register. With bit1 clear, bit0 clears and the counter reads 0xFFFFFFFF.
- R6: A control write with bit4=1 clears pending, and a write with bit4=0 leaves it unchanged. An expiry on the same edge as a clearing write leaves pending set.
- R7: A control write with bit2 set copies the reload register into the counter on that edge. Bit2 always reads back as 0.
- R8: A write to a channel counter sets its value. The channel counts only while bit0 is set.
- R9: Offset 0x08 always reads NUM_CH | (BASE_IRQ<<3) | (1<<8) | (1<<9), which is 0x342 for the defaults, and writes to it are ignored.
- R10: Reads of unmapped offsets return 0, and writes to them change no register. Unmapped offsets are word +0xC of any window, any address with bits 1:0 non-zero, and any channel window beyond NUM_CH.
- R11: After reset every prescaler, counter, reload and control register reads 0, and all irq outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, 0 when not selected |
| irq | output | NUM_CH | One-cycle expiry pulse per channel |

## Verification
The bound checker watches several relationships on every clock:
- Every prescaler tick is followed by a reload, and every non-tick cycle by a decrement.
- Every interrupt pulse coincides with the pending flag and follows a tick.
- Pending only falls after a clearing control write to that same channel.
- The unit word and the unmapped word read correctly whenever they are addressed.

The bench scenarios are needed for the end-to-end timing: that N loads give N+1 ticks, and that the interrupt period scales with the prescaler reload. They also cover the stop/restart choice, the load-bit effect and readback, and the same-edge race between expiry and a pending-clear write.

// File: rtl/ttu_pkg.sv
`timescale 1ns/1ps
// Package ttu_pkg
// Shared constants for the timer unit: bit positions in the channel
// control word and the register selector decoded from address bits 3:2.
package ttu_pkg;
    localparam int CFG_EN = 0;   // channel enable
    localparam int CFG_AR = 1;   // auto-restart on expiry
    localparam int CFG_LD = 2;   // load counter from reload (reads 0)
    localparam int CFG_IE = 3;   // interrupt enable
    localparam int CFG_PD = 4;   // sticky pending flag
    localparam int CFG_W  = 5;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_RLD  = 2'd1,
        REG_CFG  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ttu_decode.sv
`timescale 1ns/1ps
// Module ttu_decode
// Purely combinational address decode. Splits a byte address into the
// unit window (0x00-0x0F), one-hot channel windows (0x10 per channel),
// and a register selector. Assumes ADDR_W >= 8; any set bit above bit 7
// or in bits 1:0 makes the access unmapped.
module ttu_decode
    import ttu_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              unit_hit,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_e          reg_sel
);
    logic hi_zero;
    logic aligned;

    // Qualify the address: upper bits clear and word aligned.
    always_comb begin
        hi_zero  = ((addr >> 8) == '0);
        aligned  = (addr[1:0] == 2'b00);
        reg_sel  = aligned ? reg_sel_e'(addr[3:2]) : REG_NONE;
        unit_hit = hi_zero && (addr[7:4] == 4'd0);
    end

    // One comparator per channel window.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_win
        always_comb ch_hit[i] = hi_zero && (addr[7:4] == 4'(i + 1));
    end
endmodule

// File: rtl/ttu_prescaler.sv
`timescale 1ns/1ps
// Module ttu_prescaler
// Shared divider. Counts down once per clock; when the count is zero it
// raises tick for that cycle and reloads. A reload of 0 therefore ticks
// every clock. A value write overrides the count on its edge.
module ttu_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_we,
    input  logic             rld_we,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] count,
    output logic [PRE_W-1:0] reload,
    output logic             tick
);
    // Tick whenever the count has run out.
    always_comb tick = (count == '0);

    // Reload register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (rld_we) reload <= wdata;
    end

    // Down-counter with software override.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (val_we) count <= wdata;
        else if (tick)   count <= reload;
        else             count <= count - 1'b1;
    end
endmodule

// File: rtl/ttu_channel.sv
`timescale 1ns/1ps
// Module ttu_channel
// One down-counting channel. Expires when it is enabled, a tick arrives
// and the counter already holds zero (underflow). On expiry it either
// reloads (auto-restart) or wraps and clears its enable. Software writes
// win over expiry for counter and enable; expiry wins over a pending
// clear. Assumes CNT_W <= DATA_W.
module ttu_channel
    import ttu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_we,
    input  logic              rld_we,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  counter,
    output logic [CNT_W-1:0]  reload,
    output logic [CFG_W-1:0]  cfg_rd,
    output logic              pend,
    output logic              irq
);
    logic en, ar, ie;
    logic uflow;

    // Underflow condition for this cycle.
    always_comb uflow = tick && en && (counter == '0);

    // Readback of the control word; load bit never stored.
    always_comb cfg_rd = {pend, ie, 1'b0, ar, en};

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (rld_we) reload <= wdata[CNT_W-1:0];
    end

    // Counter: load bit, direct write, restart, then count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        counter <= '0;
        else if (cfg_we && wdata[CFG_LD])  counter <= reload;
        else if (cnt_we)                   counter <= wdata[CNT_W-1:0];
        else if (uflow && ar)              counter <= reload;
        else if (tick && en)               counter <= counter - 1'b1;
    end

    // Control bits; a stopping expiry drops enable unless rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
            ar <= 1'b0;
            ie <= 1'b0;
        end else if (cfg_we) begin
            en <= wdata[CFG_EN];
            ar <= wdata[CFG_AR];
            ie <= wdata[CFG_IE];
        end else if (uflow && !ar) begin
            en <= 1'b0;
        end
    end

    // Sticky pending: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend <= 1'b0;
        else if (uflow && ie)             pend <= 1'b1;
        else if (cfg_we && wdata[CFG_PD]) pend <= 1'b0;
    end

    // One-cycle interrupt pulse per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= uflow && ie;
    end
endmodule

// File: rtl/tick_timer_unit.sv
`timescale 1ns/1ps
// Module tick_timer_unit
// Top of the timer peripheral: address decode, shared prescaler, NUM_CH
// channels and the read multiplexer. Single-cycle register port, 32-bit
// accesses only. Assumes 1 <= NUM_CH <= 8 and ADDR_W >= 8.
module tick_timer_unit
    import ttu_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int BASE_IRQ = 8,
    parameter int CNT_W    = 32,
    parameter int PRE_W    = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [DATA_W-1:0] UNIT_CFG =
        DATA_W'(NUM_CH) | (DATA_W'(BASE_IRQ) << 3) | DATA_W'(32'h300);

    logic              unit_hit;
    logic [NUM_CH-1:0] ch_hit;
    reg_sel_e          reg_sel;
    logic              wr_go;
    logic              pre_tick;
    logic [PRE_W-1:0]  pre_count;
    logic [PRE_W-1:0]  pre_reload;
    logic [NUM_CH-1:0] pend_vec;
    logic [CNT_W-1:0]  ch_count  [NUM_CH];
    logic [CNT_W-1:0]  ch_reload [NUM_CH];
    logic [CFG_W-1:0]  ch_cfg    [NUM_CH];

    // Write strobe for this cycle.
    always_comb wr_go = sel && wr;

    ttu_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr     (addr),
        .unit_hit (unit_hit),
        .ch_hit   (ch_hit),
        .reg_sel  (reg_sel)
    );

    ttu_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .val_we (wr_go && unit_hit && (reg_sel == REG_CNT)),
        .rld_we (wr_go && unit_hit && (reg_sel == REG_RLD)),
        .wdata  (wdata[PRE_W-1:0]),
        .count  (pre_count),
        .reload (pre_reload),
        .tick   (pre_tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ttu_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (pre_tick),
            .cnt_we  (wr_go && ch_hit[i] && (reg_sel == REG_CNT)),
            .rld_we  (wr_go && ch_hit[i] && (reg_sel == REG_RLD)),
            .cfg_we  (wr_go && ch_hit[i] && (reg_sel == REG_CFG)),
            .wdata   (wdata),
            .counter (ch_count[i]),
            .reload  (ch_reload[i]),
            .cfg_rd  (ch_cfg[i]),
            .pend    (pend_vec[i]),
            .irq     (irq[i])
        );
    end

    // Read multiplexer; zero for anything unmapped or unselected.
    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (unit_hit) begin
                case (reg_sel)
                    REG_CNT: rdata = DATA_W'(pre_count);
                    REG_RLD: rdata = DATA_W'(pre_reload);
                    REG_CFG: rdata = UNIT_CFG;
                    default: rdata = '0;
                endcase
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) begin
                    case (reg_sel)
                        REG_CNT: rdata = DATA_W'(ch_count[i]);
                        REG_RLD: rdata = DATA_W'(ch_reload[i]);
                        REG_CFG: rdata = DATA_W'(ch_cfg[i]);
                        default: rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ttu_checker.sv
`timescale 1ns/1ps
// Module ttu_checker
// Protocol and behaviour properties for tick_timer_unit, attached by bind.
// Observes the register port, the irq outputs, the prescaler state and
// the per-channel pending flags.
module ttu_checker #(
    parameter int                NUM_CH     = 2,
    parameter int                PRE_W      = 16,
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [DATA_W-1:0] UNIT_CFG_V = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_pend_bit,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] irq,
    input logic              pre_tick,
    input logic [PRE_W-1:0]  pre_count,
    input logic [PRE_W-1:0]  pre_reload,
    input logic [NUM_CH-1:0] pend_vec
);
    logic pre_val_wr;

    // Software write to the prescaler value this cycle.
    always_comb pre_val_wr = sel && wr && (addr == '0);

    p_tick_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick && !pre_val_wr |=> pre_count == $past(pre_reload));

    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tick && !pre_val_wr |=> pre_count == PRE_W'($past(pre_count) - 1'b1));

    p_unit_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !wr && (addr == ADDR_W'(8)) |-> rdata == UNIT_CFG_V);

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !wr && (addr == ADDR_W'(12)) |-> rdata == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        p_irq_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> pend_vec[i]);

        p_irq_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(pre_tick));

        p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_vec[i]) |->
                $past(sel && wr && wr_pend_bit && (addr == ADDR_W'(16 * (i + 1) + 8))));
    end
endmodule

bind tick_timer_unit ttu_checker #(
    .NUM_CH     (NUM_CH),
    .PRE_W      (PRE_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .UNIT_CFG_V (UNIT_CFG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .wr          (wr),
    .addr        (addr),
    .wr_pend_bit (wdata[4]),
    .rdata       (rdata),
    .irq         (irq),
    .pre_tick    (pre_tick),
    .pre_count   (pre_count),
    .pre_reload  (pre_reload),
    .pend_vec    (pend_vec)
);

// File: tb/tick_timer_unit_test.sv
`timescale 1ns/1ps
// Bench for tick_timer_unit: read expectations go through a scoreboard
// queue; a negedge monitor pops and compares them against rdata.
module tick_timer_unit_test;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sel = 1'b0;
    logic           wr = 1'b0;
    logic [7:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    rd_item_t cur;

    always #2.5 clk = ~clk;

    tick_timer_unit #(.NUM_CH(NCH), .BASE_IRQ(8)) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare every read against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && sel && !wr) begin
            if (sb_q.size() == 0) begin
                check("scoreboard empty", rdata, 32'hx);
            end else begin
                cur = sb_q.pop_front();
                check(cur.tag, rdata, cur.exp);
            end
        end
    end

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    endtask

    task automatic bus_rd(logic [7:0] a, logic [31:0] e, string tag);
        @(posedge clk); #1;
        sb_q.push_back('{exp: e, tag: tag});
        sel = 1'b1; wr = 1'b0; addr = a; wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk); #1;
            sel = 1'b0; wr = 1'b0;
        end
    endtask

    task automatic wait_irq(int ch, int limit, output int k);
        k = 0;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (irq[ch]) begin
                k = c;
                break;
            end
        end
    endtask

    // Watchdog.
    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k;
        int seen;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R11 irq after reset", 32'(irq), 32'h0);

        // R11 reset values, R9 unit word
        bus_rd(8'h00, 32'h0, "R11 prescaler value");
        bus_rd(8'h04, 32'h0, "R11 prescaler reload");
        bus_rd(8'h10, 32'h0, "R11 ch0 counter");
        bus_rd(8'h14, 32'h0, "R11 ch0 reload");
        bus_rd(8'h18, 32'h0, "R11 ch0 control");
        bus_rd(8'h28, 32'h0, "R11 ch1 control");
        bus_rd(8'h08, 32'h342, "R9 unit word");

        // R1 16-bit truncation and readback
        bus_wr(8'h04, 32'hABCD_1234);
        bus_rd(8'h04, 32'h0000_1234, "R1 prescaler reload truncated");
        bus_wr(8'h00, 32'hFFFF_0005);
        bus_rd(8'h00, 32'h0000_0005, "R1 prescaler value truncated");
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h00, 32'h0);

        // R9 read-only
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_rd(8'h08, 32'h342, "R9 unit word after write");

        // R10 unmapped writes and reads
        bus_wr(8'h30, 32'h1234_5678);
        bus_wr(8'h1C, 32'h1111_1111);
        bus_wr(8'h11, 32'h55);
        bus_wr(8'h0C, 32'h77);
        bus_rd(8'h10, 32'h0, "R10 ch0 counter untouched");
        bus_rd(8'h14, 32'h0, "R10 ch0 reload untouched");
        bus_rd(8'h20, 32'h0, "R10 ch1 counter untouched");
        bus_rd(8'h30, 32'h0, "R10 out-of-range channel read");
        bus_rd(8'h1C, 32'h0, "R10 word C read");
        bus_rd(8'h0C, 32'h0, "R10 unit word C read");
        bus_rd(8'h11, 32'h0, "R10 misaligned read");

        // R8 direct counter write, no counting while disabled
        bus_wr(8'h10, 32'd100);
        idle(3);
        bus_rd(8'h10, 32'd100, "R8 disabled counter holds");

        // R7 load bit
        bus_wr(8'h14, 32'd7);
        bus_wr(8'h18, 32'h4);
        bus_rd(8'h10, 32'd7, "R7 load copies reload");
        bus_rd(8'h18, 32'h0, "R7 load bit reads zero");

        // R3/R4/R5 one-shot expiry with interrupt
        bus_wr(8'h10, 32'd3);
        bus_wr(8'h18, 32'h09);
        idle(1);
        wait_irq(0, 20, k);
        check("R3 irq delay for N=3", 32'(k), 32'd5);
        @(negedge clk);
        check("R4 irq one cycle wide", 32'(irq[0]), 32'h0);
        bus_rd(8'h18, 32'h18, "R5 enable cleared, R4 pending set");
        bus_rd(8'h10, 32'hFFFF_FFFF, "R5 stopped counter wraps");

        // R6 write-one-to-clear
        bus_wr(8'h18, 32'h08);
        bus_rd(8'h18, 32'h18, "R6 bit4=0 keeps pending");
        bus_wr(8'h18, 32'h18);
        bus_rd(8'h18, 32'h08, "R6 bit4=1 clears pending");

        // R6 expiry on the same edge as a clear
        bus_wr(8'h10, 32'd3);
        bus_wr(8'h18, 32'h09);
        idle(3);
        bus_wr(8'h18, 32'h18);
        bus_rd(8'h18, 32'h18, "R6 expiry beats clear");
        bus_wr(8'h18, 32'h10);

        // R4 no interrupt without enable bit3
        bus_wr(8'h10, 32'd2);
        bus_wr(8'h18, 32'h01);
        idle(1);
        seen = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (irq[0]) seen++;
        end
        check("R4 no irq when bit3 clear", 32'(seen), 32'h0);
        bus_rd(8'h18, 32'h00, "R4 no pending when bit3 clear");

        // R5 auto-restart and R2 period scaling
        bus_wr(8'h14, 32'd3);
        bus_wr(8'h10, 32'd3);
        bus_wr(8'h18, 32'h0B);
        idle(1);
        wait_irq(0, 50, k);
        wait_irq(0, 50, k);
        check("R5 restart period, R2 reload 0", 32'(k), 32'd4);
        bus_wr(8'h04, 32'd2);
        idle(1);
        wait_irq(0, 100, k);
        wait_irq(0, 100, k);
        wait_irq(0, 100, k);
        check("R2 period with prescaler reload 2", 32'(k), 32'd12);
        check("R4 ch1 silent", 32'(irq[1]), 32'h0);
        bus_wr(8'h18, 32'h10);
        bus_wr(8'h18, 32'h10);
        bus_rd(8'h18, 32'h00, "R6 stopped and cleared");
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h00, 32'h0);

        // R3 on channel 1 with N=0
        bus_wr(8'h20, 32'd0);
        bus_wr(8'h28, 32'h09);
        idle(1);
        wait_irq(1, 20, k);
        check("R3 ch1 irq delay for N=0", 32'(k), 32'd2);
        check("R4 ch0 not pulsed", 32'(irq[0]), 32'h0);
        bus_rd(8'h28, 32'h18, "R4 ch1 pending");

        idle(2);
        check("scoreboard drained", 32'(sb_q.size()), 32'h0);
        finish_run();
    end
endmodule